// File: doc/BRIEF.md
# BCD Real-Time Clock Core

This block keeps calendar time in packed BCD: hundredths of a second, seconds, minutes, hours, day of week, date, month and a two-digit year. A system-clock-domain enable pulses once every 10 ms and advances the count. The carry ripples through the whole chain in the same cycle. Month lengths and leap years are corrected automatically, and the calendar stays correct through the end of the 2000–2099 century.

Software sees eight 8-bit registers. A combinational read port returns any register. A write strobe with an address and a data byte loads one register at the next clock edge. The hours register carries a 12/24-hour mode select and an AM/PM flag. The day register carries an oscillator-halt bit that freezes timekeeping. Bits that have no meaning are discarded on write and always read as zero.

A tick that arrives during a write is held back and applied in the first cycle after the write. No time is lost, and the tick advances the newly written value.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the registers read hundredths 00, seconds 00, minutes 00, hours 00 (24-hour mode), day 01, date 01, month 01 and year 00. The oscillator is running.
- R2: When running, each tick with no write in progress advances hundredths by one in BCD. Hundredths 99 wraps to 00 and carries into seconds. Seconds 59 wraps to 00 and carries into minutes. Minutes 59 wraps to 00 and carries into hours.
- R3: With hours bit 7 = 0 (24-hour mode), bits 5:0 hold hours 00–23 in BCD, with bit 5 as the tens-of-twenty digit. A carry at 23 gives 00 and advances the day.
- R4: With hours bit 7 = 1 (12-hour mode), bits 4:0 hold 12, 01 … 11 in BCD and bit 5 is PM (1 = PM). A carry at 12 gives 01. A carry at 11 gives 12 and toggles PM. The day advances only when 11 PM goes to 12 AM.
- R5: Day of week sits in day bits 2:0 and runs 1–7. On a day advance, 7 wraps to 1.
- R6: On a day advance the date wraps from the month's last date to 01 and the month increments. The last date is 31, except 30 for months 04, 06, 09 and 11, and 28 or 29 for month 02. Month 12 wraps to 01 and increments the year. Year 99 wraps to 00.
- R7: A year whose two-digit value is divisible by 4 (including 00) is a leap year, and February then ends on 29.
- R8: Day bit 5 = 1 halts all counting. Ticks arriving while halted are discarded. Writing 0 resumes counting.
- R9: Register addresses are 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year. A write loads data ANDed with the mask FF, 7F, 7F, BF, 27, 3F, 1F, FF (hex, in address order), so unused bits always read 0.
- R10: Writing the seconds register also clears hundredths to 00.
- R11: A tick coinciding with a write is applied in the cycle after the write, to the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle enable every 10 ms |
| wr_en_i | input | 1 | Register load strobe |
| wr_addr_i | input | 3 | Register address for the load |
| wr_data_i | input | 8 | Data to load |
| rd_addr_i | input | 3 | Register address for the read |
| rd_data_o | output | 8 | Selected register contents (combinational) |

## Verification
Assertions check the following on every cycle:
- Registers stay frozen without a tick.
- Hundredths clear after a seconds write.
- The hours land on midnight after a day advance.
- Day of week wraps from 7 to 1.
- Dates never reach 00.
- Unused bits read zero.
- Halting stops the count.
- A collided tick is never dropped.

Which month ends on 30 or 29, leap-year selection, the 12-hour PM toggle and multi-level carries to a new year can only be shown by the bench's preset-and-tick scenarios.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_REGS = 8;
  localparam int ADDR_W   = $clog2(NUM_REGS);

  localparam logic [ADDR_W-1:0] A_HSEC  = 3'd0;
  localparam logic [ADDR_W-1:0] A_SEC   = 3'd1;
  localparam logic [ADDR_W-1:0] A_MIN   = 3'd2;
  localparam logic [ADDR_W-1:0] A_HOUR  = 3'd3;
  localparam logic [ADDR_W-1:0] A_DAY   = 3'd4;
  localparam logic [ADDR_W-1:0] A_DATE  = 3'd5;
  localparam logic [ADDR_W-1:0] A_MONTH = 3'd6;
  localparam logic [ADDR_W-1:0] A_YEAR  = 3'd7;

  localparam int HOUR_MODE_BIT = 7;
  localparam int HOUR_PM_BIT   = 5;
  localparam int DAY_OSC_BIT   = 5;

  // writable bits per register
  function automatic logic [REG_W-1:0] wr_mask(input logic [ADDR_W-1:0] a);
    case (a)
      A_SEC, A_MIN: return 8'h7F;
      A_HOUR:       return 8'hBF;
      A_DAY:        return 8'h27;
      A_DATE:       return 8'h3F;
      A_MONTH:      return 8'h1F;
      default:      return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] bcd_to_bin(input logic [7:0] v);
    logic [7:0] t;
    t = {4'b0, v[7:4]};
    return (t << 3) + (t << 1) + {4'b0, v[3:0]};
  endfunction

  function automatic logic is_leap(input logic [7:0] yr);
    logic [7:0] b;
    b = bcd_to_bin(yr);
    return b[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // returns {day_wrap, next_hours}
  function automatic logic [8:0] hour_step(input logic [7:0] h);
    logic [7:0] hv;
    logic [7:0] nx;
    logic       pm;
    if (h[HOUR_MODE_BIT]) begin
      hv = {3'b0, h[4:0]};
      pm = h[HOUR_PM_BIT];
      if (hv == 8'h12)      return {1'b0, 1'b1, 1'b0, pm, 5'h01};
      else if (hv == 8'h11) return {pm, 1'b1, 1'b0, ~pm, 5'h12};
      else begin
        nx = bcd_inc(hv);
        return {1'b0, 1'b1, 1'b0, pm, nx[4:0]};
      end
    end else begin
      hv = {2'b0, h[5:0]};
      if (hv == 8'h23) return {1'b1, 8'h00};
      else begin
        nx = bcd_inc(hv);
        return {1'b0, 2'b00, nx[5:0]};
      end
    end
  endfunction
endpackage

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_bcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  hsec_o,
  output logic [REG_W-1:0]  sec_o,
  output logic [REG_W-1:0]  min_o,
  output logic [REG_W-1:0]  hour_o,
  output logic              day_step_o
);
  logic [REG_W-1:0] hsec_q, sec_q, min_q, hour_q;
  logic [8:0]       hour_nxt;
  logic             hsec_wrap, sec_wrap, min_wrap, hour_wrap;

  assign hour_nxt  = hour_step(hour_q);
  assign hsec_wrap = step_i && (hsec_q == 8'h99);
  assign sec_wrap  = hsec_wrap && (sec_q == 8'h59);
  assign min_wrap  = sec_wrap && (min_q == 8'h59);
  assign hour_wrap = min_wrap && hour_nxt[8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hsec_q <= '0;
      sec_q  <= '0;
      min_q  <= '0;
      hour_q <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_HSEC: hsec_q <= wr_data_i & wr_mask(A_HSEC);
        A_SEC: begin
          sec_q  <= wr_data_i & wr_mask(A_SEC);
          hsec_q <= '0;
        end
        A_MIN:  min_q  <= wr_data_i & wr_mask(A_MIN);
        A_HOUR: hour_q <= wr_data_i & wr_mask(A_HOUR);
        default: ;
      endcase
    end else if (step_i) begin
      hsec_q <= hsec_wrap ? 8'h00 : bcd_inc(hsec_q);
      if (hsec_wrap) sec_q  <= (sec_q == 8'h59) ? 8'h00 : bcd_inc(sec_q);
      if (sec_wrap)  min_q  <= (min_q == 8'h59) ? 8'h00 : bcd_inc(min_q);
      if (min_wrap)  hour_q <= hour_nxt[7:0];
    end
  end

  assign hsec_o     = hsec_q;
  assign sec_o      = sec_q;
  assign min_o      = min_q;
  assign hour_o     = hour_q;
  assign day_step_o = hour_wrap;

  // R10
  hsec_clear_on_sec_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == A_SEC) |=> (hsec_q == 8'h00));

  // R2
  time_hold_without_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !wr_en_i) |=> $stable({hsec_q, sec_q, min_q, hour_q}));

  // R3 R4
  midnight_after_day_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (day_step_o && !wr_en_i) |=> (hour_q == 8'h00 || hour_q == 8'h92));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_bcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  day_o,
  output logic [REG_W-1:0]  date_o,
  output logic [REG_W-1:0]  month_o,
  output logic [REG_W-1:0]  year_o
);
  logic [REG_W-1:0] day_q, date_q, month_q, year_q;
  logic             month_step, year_step;

  assign month_step = step_i && (date_q == month_last(month_q, year_q));
  assign year_step  = month_step && (month_q == 8'h12);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      day_q   <= 8'h01;
      date_q  <= 8'h01;
      month_q <= 8'h01;
      year_q  <= 8'h00;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_DAY:   day_q   <= wr_data_i & wr_mask(A_DAY);
        A_DATE:  date_q  <= wr_data_i & wr_mask(A_DATE);
        A_MONTH: month_q <= wr_data_i & wr_mask(A_MONTH);
        A_YEAR:  year_q  <= wr_data_i & wr_mask(A_YEAR);
        default: ;
      endcase
    end else if (step_i) begin
      day_q[2:0] <= (day_q[2:0] == 3'd7) ? 3'd1 : day_q[2:0] + 3'd1;
      date_q     <= month_step ? 8'h01 : bcd_inc(date_q);
      if (month_step) month_q <= year_step ? 8'h01 : bcd_inc(month_q);
      if (year_step)  year_q  <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
    end
  end

  assign day_o   = day_q;
  assign date_o  = date_q;
  assign month_o = month_q;
  assign year_o  = year_q;

  // R5
  weekday_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !wr_en_i && day_q[2:0] == 3'd7) |=> (day_q[2:0] == 3'd1));

  // R6
  date_never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !wr_en_i) |=> (date_q != 8'h00));
endmodule

// File: rtl/rtc_read_mux.sv
module rtc_read_mux
  import rtc_bcd_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_REGS-1:0][REG_W-1:0]  regs_i,
  input  logic [ADDR_W-1:0]               rd_addr_i,
  output logic [REG_W-1:0]                rd_data_o
);
  assign rd_data_o = regs_i[rd_addr_i];

  // R9
  unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o & ~wr_mask(rd_addr_i)) == 8'h00);
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_bcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o
);
  logic                           tick_held;
  logic                           count_en;
  logic                           osc_off;
  logic                           day_step;
  logic [REG_W-1:0]               hsec, sec, mins, hour, day, date, month, year;
  logic [NUM_REGS-1:0][REG_W-1:0] regs;

  always_ff @(posedge clk) begin
    if (!rst_n)       tick_held <= 1'b0;
    else if (wr_en_i) tick_held <= tick_held | tick_i;
    else              tick_held <= 1'b0;
  end

  assign osc_off  = day[DAY_OSC_BIT];
  assign count_en = (tick_i || tick_held) && !wr_en_i && !osc_off;

  rtc_time_chain time_i (
    .clk(clk), .rst_n(rst_n), .step_i(count_en),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .hsec_o(hsec), .sec_o(sec), .min_o(mins), .hour_o(hour),
    .day_step_o(day_step)
  );

  rtc_calendar cal_i (
    .clk(clk), .rst_n(rst_n), .step_i(day_step),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .day_o(day), .date_o(date), .month_o(month), .year_o(year)
  );

  assign regs = {year, month, date, day, hour, mins, sec, hsec};

  rtc_read_mux rd_i (
    .clk(clk), .rst_n(rst_n), .regs_i(regs),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );

  // R8
  halt_freezes_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_off && !wr_en_i) |=> $stable(hsec));

  // R11
  collided_tick_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && wr_en_i) ##1 (!wr_en_i && !osc_off) |-> count_en);
endmodule

// File: tb/rtc_bcd_core_tb_top.sv
module rtc_bcd_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  rtc_bcd_core dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  // byte i of pre/exp is register i: {year,month,date,day,hour,min,sec,hsec}
  typedef struct packed {
    logic [63:0] pre;
    logic [15:0] nt;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{64'h23_06_15_03_12_34_56_78, 16'd1,   64'h23_06_15_03_12_34_56_79},
    '{64'h23_06_15_03_12_34_56_99, 16'd1,   64'h23_06_15_03_12_34_57_00},
    '{64'h99_12_31_07_23_59_59_99, 16'd1,   64'h00_01_01_01_00_00_00_00},
    '{64'h23_02_28_02_23_59_59_99, 16'd1,   64'h23_03_01_03_00_00_00_00},
    '{64'h24_02_28_02_23_59_59_99, 16'd1,   64'h24_02_29_03_00_00_00_00},
    '{64'h24_02_29_04_23_59_59_99, 16'd1,   64'h24_03_01_05_00_00_00_00},
    '{64'h21_04_30_05_23_59_59_99, 16'd1,   64'h21_05_01_06_00_00_00_00},
    '{64'h21_01_30_06_23_59_59_99, 16'd1,   64'h21_01_31_07_00_00_00_00},
    '{64'h22_07_10_01_91_59_59_99, 16'd1,   64'h22_07_10_01_B2_00_00_00},
    '{64'h22_07_10_01_B1_59_59_99, 16'd1,   64'h22_07_11_02_92_00_00_00},
    '{64'h22_07_10_01_92_59_59_99, 16'd1,   64'h22_07_10_01_81_00_00_00},
    '{64'h22_07_10_24_10_20_30_40, 16'd5,   64'h22_07_10_24_10_20_30_40},
    '{64'h99_E9_C7_D2_49_92_C5_33, 16'd0,   64'h99_09_07_02_09_12_45_33},
    '{64'h22_07_10_01_19_59_59_99, 16'd1,   64'h22_07_10_01_20_00_00_00},
    '{64'h22_07_10_01_09_59_59_99, 16'd1,   64'h22_07_10_01_10_00_00_00},
    '{64'h00_01_01_01_00_00_58_50, 16'd150, 64'h00_01_01_01_00_01_00_00},
    '{64'h00_02_28_03_23_59_59_99, 16'd1,   64'h00_02_29_04_00_00_00_00}
  };

  function automatic string vec_req(input int i);
    case (i)
      0, 1, 15:     return "R2";
      2:            return "R5/R6";
      3, 4, 5, 16:  return "R7";
      6, 7:         return "R6";
      8, 9, 10:     return "R4";
      11:           return "R8";
      12:           return "R9";
      default:      return "R3";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic preset(input logic [63:0] v);
    wr(3'd1, v[15:8]);
    wr(3'd0, v[7:0]);
    for (int r = 2; r < 8; r++) wr(3'(r), v[r*8 +: 8]);
  endtask

  task automatic compare_all(input string req, input logic [63:0] e);
    logic [7:0] d;
    for (int r = 0; r < 8; r++) begin
      rd(3'(r), d);
      check(req, $sformatf("reg%0d", r), d, e[r*8 +: 8]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    compare_all("R1", 64'h00_01_01_01_00_00_00_00);

    for (int i = 0; i < NV; i++) begin
      preset(VECS[i].pre);
      ticks(int'(VECS[i].nt));
      @(negedge clk);
      compare_all(vec_req(i), VECS[i].exp);
    end

    // R10: seconds write clears hundredths
    wr(3'd4, 8'h01);
    wr(3'd0, 8'h55);
    wr(3'd1, 8'h30);
    rd(3'd0, d); check("R10", "hsec", d, 8'h00);
    rd(3'd1, d); check("R10", "sec", d, 8'h30);

    // R11: tick colliding with a write is applied afterwards to the new value
    wr(3'd0, 8'h10);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h05; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    @(negedge clk);
    rd(3'd0, d); check("R11", "hsec", d, 8'h11);
    rd(3'd2, d); check("R11", "min", d, 8'h05);

    // R8: ticks while halted are lost, counting resumes after clearing the bit
    wr(3'd4, 8'h23);
    ticks(3);
    rd(3'd0, d); check("R8", "hsec halted", d, 8'h11);
    wr(3'd4, 8'h03);
    ticks(1);
    rd(3'd0, d); check("R8", "hsec resumed", d, 8'h12);
    rd(3'd4, d); check("R8", "day", d, 8'h03);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule